// File: doc/BRIEF.md
# Reciprocal Frequency Counter

This block measures the frequency of an asynchronous input without range switching. Two free-running counters run side by side. One counts input rising edges. The other counts system-clock time through a programmable prescaler. On a chosen input edge both counters are copied together into holding registers. Software divides the cycle difference by the time difference between two captures, so each result spans a whole number of input cycles. The same precision therefore holds from a fraction of a hertz up to tens of megahertz.

The block has two capture modes. In the armed mode, a software arm command sets up a single capture, which fires on the first input rising edge after the arm. The hardware then drops the arm. In the every-M mode, a capture fires automatically after every M input rising edges, which gives a steady update rate. The input passes through a synchronizer first, and only rising edges of the synchronized signal are counted.

The capture sequencer has three states:
- `ST_IDLE` waits.
- `ST_ARMED` waits for one edge.
- `ST_RUN_M` counts down M edges per capture.

Its transitions are:
- arm (`ST_IDLE` to `ST_ARMED`, on an arm command while the mode bit is 0).
- fire (`ST_ARMED` to `ST_IDLE`, on an input edge, capturing).
- enter-M (`ST_IDLE` or `ST_ARMED` to `ST_RUN_M`, when the mode bit is 1).
- leave-M (`ST_RUN_M` to `ST_IDLE`, when the mode bit returns to 0).
- wrap (`ST_RUN_M` to itself, on the M-th edge, capturing and reloading).

Register map (word address on `reg_addr`):
- 0 is config. Bit 0 is the mode bit (1 selects every-M). Bits 15:8 are the prescaler N.
- 1 is command and status. Writing 1 to bit 0 arms, writing 1 to bit 1 clears done, and writing 1 to bit 2 clears overflow. On read, bit 0 is armed, bit 1 is done and bit 2 is overflow.
- 2 is M, the low 16 bits.
- 3 is the captured time.
- 4 is the captured cycle count. Reading it marks the pair as read.

Top module: `recip_freq_counter`

## Requirements
- R1: After reset, every readable register returns 0. Both `done_o` and `ovf_o` are 0.
- R2: An arm command alone captures nothing. The first synchronized rising edge after the arm captures both counters once, clears the armed status bit (bit 0 of address 1) and sets done (bit 1). Later edges leave the captured pair unchanged until the next arm.
- R3: A capture that occurs while the previous pair is unread (no read of address 4 since the last capture) sets the sticky overflow bit (bit 2 of address 1). Only a command write with bit 2 set clears it. A capture after the pair has been read leaves overflow at 0.
- R4: The captured cycle count equals the number of input rising edges before the capturing edge. Two captures therefore differ by exactly the number of edges between them.
- R5: The captured time counts prescaler ticks. With N equal to 0 or 1, two captures differ by exactly the number of clock cycles between their capturing edges.
- R6: The prescaler N field (config bits 15:8) divides the time count by N. N equal to 0 acts as divide-by-1. Over a span of D clock cycles, the time difference is within 1 of D/N.
- R7: With the mode bit set, a capture fires on every M-th input rising edge counted from entry into the mode. The captured cycle counts differ by M, and an M of 0 behaves as 1.
- R8: Done stays set until a command write with bit 1 set. The captured time and cycle values stay stable between captures.
- R9: Only rising edges of the input count. A falling edge neither advances the cycle count nor triggers an armed capture.
- R10: Clearing the mode bit stops automatic captures. The block returns to idle, and armed reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous input whose frequency is measured |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks the pair read when the address is 4) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| done_o | output | 1 | A capture has occurred and is not yet acknowledged |
| ovf_o | output | 1 | Sticky overflow: a pair was overwritten before it was read |

## Verification
The counting path is driven with pulse trains of known spacing. A train of unarmed edges between two armed captures shows that the cycle count includes every edge. The exact clock spacing of the capturing edges, with N set to 0 and then to 4, checks the time count against the divide rule.

A level held high across an arm, followed by a falling edge, tells a rising-edge trigger apart from a level or any-edge trigger. Trains of M-1 and then M edges in the every-M mode separate a correct countdown from an off-by-one. Back-to-back captures with and without an intervening read of the cycle register separate the overflow rule from a plain capture counter.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN_M = 2'd2
    } cap_state_e;

    localparam logic [2:0] A_CONFIG = 3'd0;
    localparam logic [2:0] A_CMD    = 3'd1;
    localparam logic [2:0] A_MCOUNT = 3'd2;
    localparam logic [2:0] A_TIME   = 3'd3;
    localparam logic [2:0] A_CYCLES = 3'd4;

    localparam int CFG_MODE_BIT = 0;
    localparam int CFG_PRE_LSB  = 8;

    localparam int CMD_ARM      = 0;
    localparam int CMD_CLR_DONE = 1;
    localparam int CMD_CLR_OVF  = 2;

    localparam int ST_BIT_ARMED = 0;
    localparam int ST_BIT_DONE  = 1;
    localparam int ST_BIT_OVF   = 2;

endpackage

// File: rtl/rfc_sync_edge.sv
module rfc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    // chain_q[STAGES-1] is the synchronized level; chain_q[STAGES] is its delayed copy
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/rfc_timebase.sv
module rfc_timebase #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc,
    output logic [CNT_W-1:0] time_cnt
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] n_eff;
    logic             tick;

    assign n_eff = (presc == '0) ? PRE_W'(1) : presc;
    assign tick  = (pre_q >= n_eff - PRE_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            time_cnt <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            if (tick) begin
                time_cnt <= time_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/rfc_event_counter.sv
module rfc_event_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rfc_capture_fsm.sv
module rfc_capture_fsm
    import rfc_pkg::*;
#(
    parameter int M_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_m,
    input  logic           arm_req,
    input  logic           rise,
    input  logic [M_W-1:0] m_val,
    output logic           capture,
    output logic           armed
);
    cap_state_e     state_q, state_d;
    logic [M_W-1:0] left_q;
    logic [M_W-1:0] m_eff;
    logic           last_edge;

    assign m_eff     = (m_val == '0) ? M_W'(1) : m_val;
    assign last_edge = (left_q <= M_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_m)       state_d = ST_RUN_M;
                else if (arm_req) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (mode_m)    state_d = ST_RUN_M;
                else if (rise) state_d = ST_IDLE;
            end
            ST_RUN_M: begin
                if (!mode_m) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and edge countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_RUN_M) begin
                left_q <= m_eff;
            end else if (rise) begin
                left_q <= last_edge ? m_eff : left_q - M_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        armed   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: begin
                armed   = 1'b1;
                capture = rise && !mode_m;
            end
            ST_RUN_M: capture = rise && mode_m && last_edge;
            default:  ;
        endcase
    end

endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter
    import rfc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 8,
    parameter int M_W         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              done_o,
    output logic              ovf_o
);
    logic             cfg_mode;
    logic [PRE_W-1:0] cfg_presc;
    logic [M_W-1:0]   m_reg;
    logic [CNT_W-1:0] cap_time_q, cap_cyc_q;
    logic [CNT_W-1:0] time_cnt, cyc_cnt;
    logic             done_q, ovf_q, unread_q;
    logic             edge_rise, cap_fire, armed;
    logic             wr_cfg, wr_cmd, wr_m, rd_cyc;
    logic             arm_req, clr_done, clr_ovf;
    logic             unused_wdata;

    assign wr_cfg   = reg_wr && (reg_addr == ADDR_W'(A_CONFIG));
    assign wr_cmd   = reg_wr && (reg_addr == ADDR_W'(A_CMD));
    assign wr_m     = reg_wr && (reg_addr == ADDR_W'(A_MCOUNT));
    assign rd_cyc   = reg_rd && (reg_addr == ADDR_W'(A_CYCLES));
    assign arm_req  = wr_cmd && reg_wdata[CMD_ARM];
    assign clr_done = wr_cmd && reg_wdata[CMD_CLR_DONE];
    assign clr_ovf  = wr_cmd && reg_wdata[CMD_CLR_OVF];
    assign unused_wdata = ^reg_wdata;

    rfc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(edge_rise)
    );

    rfc_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_time (
        .clk(clk), .rst_n(rst_n), .presc(cfg_presc), .time_cnt(time_cnt)
    );

    rfc_event_counter #(.CNT_W(CNT_W)) u_cycles (
        .clk(clk), .rst_n(rst_n), .inc(edge_rise), .count(cyc_cnt)
    );

    rfc_capture_fsm #(.M_W(M_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_m(cfg_mode), .arm_req(arm_req),
        .rise(edge_rise), .m_val(m_reg), .capture(cap_fire), .armed(armed)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode  <= 1'b0;
            cfg_presc <= '0;
            m_reg     <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_mode  <= reg_wdata[CFG_MODE_BIT];
                cfg_presc <= reg_wdata[CFG_PRE_LSB +: PRE_W];
            end
            if (wr_m) begin
                m_reg <= reg_wdata[M_W-1:0];
            end
        end
    end

    // holding pair and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_time_q <= '0;
            cap_cyc_q  <= '0;
            done_q     <= 1'b0;
            ovf_q      <= 1'b0;
            unread_q   <= 1'b0;
        end else begin
            if (cap_fire) begin
                cap_time_q <= time_cnt;
                cap_cyc_q  <= cyc_cnt;
            end
            if (cap_fire)      done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
            if (cap_fire && unread_q) ovf_q <= 1'b1;
            else if (clr_ovf)         ovf_q <= 1'b0;
            if (cap_fire)    unread_q <= 1'b1;
            else if (rd_cyc) unread_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_CONFIG): begin
                reg_rdata[CFG_MODE_BIT]          = cfg_mode;
                reg_rdata[CFG_PRE_LSB +: PRE_W]  = cfg_presc;
            end
            ADDR_W'(A_CMD): begin
                reg_rdata[ST_BIT_ARMED] = armed;
                reg_rdata[ST_BIT_DONE]  = done_q;
                reg_rdata[ST_BIT_OVF]   = ovf_q;
            end
            ADDR_W'(A_MCOUNT): reg_rdata[M_W-1:0] = m_reg;
            ADDR_W'(A_TIME):   reg_rdata = cap_time_q;
            ADDR_W'(A_CYCLES): reg_rdata = cap_cyc_q;
            default:           reg_rdata = '0;
        endcase
    end

    assign done_o = done_q;
    assign ovf_o  = ovf_q;

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic             capture,
    input logic             armed,
    input logic             mode_m,
    input logic             done,
    input logic             ovf,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] cap_time,
    input logic [CNT_W-1:0] cap_cycles,
    input logic [CNT_W-1:0] cyc_cnt
);
    p_capture_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> rise);

    p_armed_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !mode_m) |=> !armed);

    p_idle_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !mode_m) |-> !capture);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    p_cycles_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cyc_cnt == $past(cyc_cnt) + CNT_W'(1)));

    p_done_after_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> done);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(cap_time) && $stable(cap_cycles)));

    p_no_count_without_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(cyc_cnt));

endmodule

bind recip_freq_counter rfc_checker #(.CNT_W(CNT_W)) u_rfc_checker (
    .clk(clk), .rst_n(rst_n), .rise(edge_rise), .capture(cap_fire),
    .armed(armed), .mode_m(cfg_mode), .done(done_q), .ovf(ovf_q),
    .ovf_clr(clr_ovf), .cap_time(cap_time_q), .cap_cycles(cap_cyc_q),
    .cyc_cnt(cyc_cnt)
);

// File: tb/tb_recip_freq_counter.sv
module tb_recip_freq_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sig_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        done_o, ovf_o;

    int          n_checks = 0;
    int          n_fail = 0;
    longint      cyc = 0;

    recip_freq_counter dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .done_o(done_o), .ovf_o(ovf_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one rising edge driven at a negedge; returns the bench cycle of the rise
    task automatic pulse(output longint t_rise);
        @(negedge clk);
        sig_in = 1'b1;
        t_rise = cyc;
        idle(5);
        sig_in = 1'b0;
        idle(5);
    endtask

    task automatic pulses(input int n);
        longint t;
        for (int i = 0; i < n; i++) pulse(t);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check(d == 0, "R1 register", d, 0);
        end
        check(done_o == 0 && ovf_o == 0, "R1 flags", {done_o, ovf_o}, 0);
    endtask

    // two armed captures separated by unarmed edges; checks counts and time span
    task automatic measure(input int presc, input int extra);
        logic [31:0] a1, b1, a2, b2, st, d;
        longint t1, t2, span;
        wr(3'd0, 32'(presc) << 8);
        wr(3'd1, 32'h2);
        rd(3'd4, d);
        wr(3'd1, 32'h1);
        rd(3'd1, st);
        check(st[0] == 1 && st[1] == 0, "R2 armed no capture", st, 1);
        idle(3);
        pulse(t1);
        rd(3'd1, st);
        check(st[0] == 0 && st[1] == 1, "R2 fired", st, 2);
        rd(3'd3, a1);
        rd(3'd4, b1);
        pulses(extra);
        rd(3'd3, d);
        check(d == a1, "R2 later edges ignored", d, a1);
        wr(3'd1, 32'h2);
        wr(3'd1, 32'h1);
        idle(3);
        pulse(t2);
        idle(2);
        rd(3'd3, a2);
        rd(3'd4, b2);
        check(b2 - b1 == extra + 1, "R4 cycle span", b2 - b1, extra + 1);
        span = t2 - t1;
        if (presc <= 1) begin
            check(a2 - a1 == span, "R5 time span", a2 - a1, span);
        end else begin
            check((longint'(a2 - a1) - span / presc) <= 1 && (span / presc - longint'(a2 - a1)) <= 1,
                  "R6 prescaled span", a2 - a1, span / presc);
        end
        idle(4);
        rd(3'd3, d);
        check(d == a2, "R8 hold stable", d, a2);
    endtask

    task automatic test_overflow();
        logic [31:0] d, st;
        longint t;
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h6);
        rd(3'd4, d);
        wr(3'd1, 32'h1); idle(2); pulse(t);
        rd(3'd4, d);
        wr(3'd1, 32'h1); idle(2); pulse(t);
        rd(3'd1, st);
        check(st[2] == 0, "R3 read pair no overflow", st[2], 0);
        wr(3'd1, 32'h1); idle(2); pulse(t);
        rd(3'd1, st);
        check(st[2] == 1 && ovf_o == 1, "R3 overflow set", st[2], 1);
        pulses(2);
        check(ovf_o == 1, "R3 sticky", ovf_o, 1);
        wr(3'd1, 32'h4);
        rd(3'd1, st);
        check(st[2] == 0, "R3 cleared", st[2], 0);
    endtask

    task automatic test_done_clear();
        logic [31:0] st;
        longint t;
        wr(3'd1, 32'h1); idle(2); pulse(t);
        idle(6);
        check(done_o == 1, "R8 done held", done_o, 1);
        wr(3'd1, 32'h2);
        rd(3'd1, st);
        check(st[1] == 0, "R8 done cleared", st[1], 0);
    endtask

    task automatic test_falling();
        logic [31:0] st;
        wr(3'd1, 32'h2);
        @(negedge clk); sig_in = 1'b1;
        idle(6);
        wr(3'd1, 32'h1);
        @(negedge clk); sig_in = 1'b0;
        idle(6);
        rd(3'd1, st);
        check(st[0] == 1 && st[1] == 0, "R9 falling edge ignored", st, 1);
        @(negedge clk); sig_in = 1'b1;
        idle(6);
        rd(3'd1, st);
        check(st[0] == 0 && st[1] == 1, "R9 rising edge fires", st, 2);
        @(negedge clk); sig_in = 1'b0;
        idle(4);
    endtask

    task automatic test_every_m();
        logic [31:0] st, c1, c2;
        wr(3'd0, 32'h0);
        wr(3'd2, 32'd4);
        wr(3'd1, 32'h6);
        wr(3'd0, 32'h1);
        idle(2);
        pulses(3);
        rd(3'd1, st);
        check(st[1] == 0, "R7 no capture before M", st[1], 0);
        pulses(1);
        rd(3'd1, st);
        check(st[1] == 1, "R7 capture at M", st[1], 1);
        rd(3'd4, c1);
        wr(3'd1, 32'h2);
        pulses(4);
        rd(3'd4, c2);
        check(c2 - c1 == 4, "R7 M spacing", c2 - c1, 4);
        wr(3'd0, 32'h0);
        wr(3'd2, 32'd0);
        wr(3'd1, 32'h6);
        wr(3'd0, 32'h1);
        idle(2);
        pulses(1);
        rd(3'd4, c1);
        pulses(1);
        rd(3'd4, c2);
        check(c2 - c1 == 1, "R7 M zero as one", c2 - c1, 1);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h2);
        pulses(3);
        rd(3'd1, st);
        check(st[1:0] == 2'b00, "R10 mode off stops capture", st[1:0], 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        test_reset();
        measure(0, 6);
        measure(4, 9);
        test_overflow();
        test_done_clear();
        test_falling();
        test_every_m();
        summary();
    end

endmodule